// File: doc/BRIEF.md
# Comma-Aligned Serial Receive Front End

This block accepts one serial bit per clock and assembles the stream into 10-bit code groups. The bit comes from one of two receive lanes, or from the block's own transmit stream when loopback is on. Every group it delivers comes with a one-cycle valid strobe. The serial transmit bit passes straight through to the transmit output. During loopback that output is held at a steady 1.

When the alignment enable is high, the block watches the incoming stream for a 7-bit comma prefix. When it finds one, it moves the word boundary so that the next word starts with the first bit of that comma. When that aligned word is delivered, a byte-sync flag pulses beside it.

A small state machine tracks alignment and has two states. `ALIGN_IDLE` is the state after reset and whenever no realignment is waiting. `ALIGN_PEND` means a comma has moved the boundary and the aligned word has not been delivered yet. There are three transitions:
- IDLE to PEND, named *realign*, on a comma seen while the enable is high.
- PEND to PEND, also *realign*, on a further comma.
- PEND to IDLE, named *deliver*, when the aligned word completes, or *abandon*, when the enable drops first.

Top module: `comma_rx_frontend`

## Requirements
- R1: With loopback low and the lane select low, the receive path takes its bits from lane A.
- R2: With loopback low and the lane select high, the receive path takes its bits from lane B.
- R3: With loopback high, the receive path takes its bits from the transmit serial input, whatever the lane select is, and the transmit output is a constant 1. With loopback low, the transmit output equals the transmit serial input in the same cycle.
- R4: Received bits fill a 10-bit word in arrival order, so the first bit lands in bit 0. Each time ten bits have arrived, the word appears on the word output with a one-cycle valid strobe. Both appear in the cycle after the clock edge that takes the tenth bit. The word output holds its value between strobes.
- R5: A comma exists when the seven most recent bits, oldest first, are 0,0,1,1,1,1,1. If this happens while alignment is enabled, the partial word is dropped with no strobe that cycle. The boundary moves so that the comma's first bit becomes bit 0 of the next word. That word therefore completes three bits later.
- R6: Byte sync is active high. It pulses for one cycle together with the valid strobe of the first word that starts at a comma. It pulses only if the alignment enable was high at the comma and stayed high up to the edge that completes that word.
- R7: While the alignment enable is low, a comma has no effect. The 10-bit word rhythm continues unchanged and byte sync stays low.
- R8: A synchronous active-high reset clears the shift register and bit count, returns the alignment state to idle, and drives the word, valid strobe and byte sync to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_a_in | input | 1 | Serial bit from lane A |
| lane_b_in | input | 1 | Serial bit from lane B |
| lane_b_sel | input | 1 | 1 selects lane B, 0 selects lane A |
| loop_en | input | 1 | Loopback: receive from the transmit stream, hold transmit output at 1 |
| align_en | input | 1 | Enables comma alignment and byte sync |
| tx_ser_in | input | 1 | Transmit serial bit |
| tx_ser_out | output | 1 | Transmit serial output |
| rx_word | output | 10 | Aligned received word, first bit in bit 0 |
| rx_word_vld | output | 1 | One-cycle strobe marking a new word |
| byte_sync | output | 1 | Pulses with the first word aligned to a comma |

## Verification
The assertions assume that reset is applied before the first real bit. They also assume that the alignment enable is a level that firmware sets, which may change on any cycle. The byte-sync check only looks one cycle back at that enable. The random stimulus changes the enable, the lane select and loopback only on occasional cycles. It lets natural and injected commas land at any bit offset. Directed runs place a comma at each of the ten offsets, send commas with alignment off, send commas on the unselected lane, and enter and leave loopback.

// File: rtl/crx_pkg.sv
package crx_pkg;
    localparam int WORD_W    = 10;
    localparam int COMMA_LEN = 7;
    // bit i is the i-th received bit of the comma prefix (0,0,1,1,1,1,1)
    localparam logic [COMMA_LEN-1:0] COMMA_PAT = 7'b1111100;

    typedef enum logic {
        ALIGN_IDLE,
        ALIGN_PEND
    } align_state_e;
endpackage

// File: rtl/crx_lane_mux.sv
module crx_lane_mux (
    input  logic lane_a_in,
    input  logic lane_b_in,
    input  logic lane_b_sel,
    input  logic loop_en,
    input  logic tx_ser_in,
    output logic rx_bit,
    output logic tx_ser_out
);
    always_comb begin
        if (loop_en)
            rx_bit = tx_ser_in;
        else if (lane_b_sel)
            rx_bit = lane_b_in;
        else
            rx_bit = lane_a_in;
    end

    assign tx_ser_out = loop_en | tx_ser_in;
endmodule

// File: rtl/crx_comma_detect.sv
module crx_comma_detect #(
    parameter int                   PAT_LEN = crx_pkg::COMMA_LEN,
    parameter logic [PAT_LEN-1:0]   PAT     = crx_pkg::COMMA_PAT
) (
    input  logic [PAT_LEN-1:0] window,   // window[0] is the oldest bit
    output logic               hit
);
    logic [PAT_LEN-1:0] bit_eq;

    for (genvar i = 0; i < PAT_LEN; i++) begin : g_cmp
        assign bit_eq[i] = (window[i] == PAT[i]);
    end

    assign hit = &bit_eq;
endmodule

// File: rtl/crx_word_framer.sv
module crx_word_framer
    import crx_pkg::*;
#(
    parameter int W       = crx_pkg::WORD_W,
    parameter int PAT_LEN = crx_pkg::COMMA_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_bit,
    input  logic         align_en,
    output logic [W-1:0] word_q,
    output logic         vld_q,
    output logic         sync_q
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] CNT_REALGN = CNT_W'(PAT_LEN);

    logic [W-1:0]     sr_q, sr_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    align_state_e     state_q, state_d;
    logic             comma_hit, realign, word_done;

    assign sr_nxt = {rx_bit, sr_q[W-1:1]};

    crx_comma_detect #(.PAT_LEN(PAT_LEN), .PAT(COMMA_PAT)) u_det (
        .window (sr_nxt[W-1 -: PAT_LEN]),
        .hit    (comma_hit)
    );

    assign realign   = comma_hit & align_en;
    assign word_done = !realign && (cnt_q == CNT_LAST);

    always_comb begin
        if (realign)
            cnt_d = CNT_REALGN;
        else if (word_done)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALIGN_IDLE: if (realign) state_d = ALIGN_PEND;
            ALIGN_PEND: begin
                if (realign)
                    state_d = ALIGN_PEND;
                else if (word_done || !align_en)
                    state_d = ALIGN_IDLE;
            end
            default: state_d = ALIGN_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ALIGN_IDLE;
            sr_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            sr_q    <= sr_nxt;
            cnt_q   <= cnt_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            vld_q  <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            vld_q  <= word_done;
            sync_q <= word_done && (state_q == ALIGN_PEND) && align_en;
            if (word_done)
                word_q <= sr_nxt;
        end
    end

    // R4
    valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q);
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST);
    // R5
    realign_drop_chk: assert property (@(posedge clk) disable iff (rst)
        realign |=> !vld_q);
    // R6
    sync_with_word_chk: assert property (@(posedge clk) disable iff (rst)
        sync_q |-> vld_q);
    // R6
    sync_enable_chk: assert property (@(posedge clk) disable iff (rst)
        sync_q |-> $past(align_en));
endmodule

// File: rtl/comma_rx_frontend.sv
module comma_rx_frontend
    import crx_pkg::*;
#(
    parameter int W       = crx_pkg::WORD_W,
    parameter int PAT_LEN = crx_pkg::COMMA_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lane_a_in,
    input  logic         lane_b_in,
    input  logic         lane_b_sel,
    input  logic         loop_en,
    input  logic         align_en,
    input  logic         tx_ser_in,
    output logic         tx_ser_out,
    output logic [W-1:0] rx_word,
    output logic         rx_word_vld,
    output logic         byte_sync
);
    logic rx_bit;

    crx_lane_mux u_mux (
        .lane_a_in  (lane_a_in),
        .lane_b_in  (lane_b_in),
        .lane_b_sel (lane_b_sel),
        .loop_en    (loop_en),
        .tx_ser_in  (tx_ser_in),
        .rx_bit     (rx_bit),
        .tx_ser_out (tx_ser_out)
    );

    crx_word_framer #(.W(W), .PAT_LEN(PAT_LEN)) u_frm (
        .clk      (clk),
        .rst      (rst),
        .rx_bit   (rx_bit),
        .align_en (align_en),
        .word_q   (rx_word),
        .vld_q    (rx_word_vld),
        .sync_q   (byte_sync)
    );

    // R3
    loop_tx_high_chk: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> tx_ser_out);
endmodule

// File: tb/comma_rx_frontend_tb.sv
module comma_rx_frontend_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_in = 1'b0, b_in = 1'b0, sel = 1'b0, loop = 1'b0, algn = 1'b0, tx_in = 1'b0;
    logic       tx_out, vld, sync;
    logic [9:0] word;

    int checks = 0, errors = 0, sync_seen = 0;
    logic [9:0] last_sync_word = '0;

    // expected state, built from the requirements
    logic [9:0] m_sr = '0, m_word = '0;
    int         m_cnt = 0;
    bit         m_pend = 0, m_vld = 0, m_sync = 0;

    always #5 clk = ~clk;

    comma_rx_frontend u_dut (
        .clk(clk), .rst(rst), .lane_a_in(a_in), .lane_b_in(b_in),
        .lane_b_sel(sel), .loop_en(loop), .align_en(algn), .tx_ser_in(tx_in),
        .tx_ser_out(tx_out), .rx_word(word), .rx_word_vld(vld), .byte_sync(sync)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_comma(input logic [9:0] v);
        return v[9:3] == 7'b1111100;   // R5: oldest at bit 3
    endfunction

    task automatic step(input bit r, input bit a, input bit b, input bit s,
                        input bit l, input bit e, input bit t);
        logic       bsel;
        logic [9:0] nxt;
        string      lt;
        @(negedge clk);
        lt = l ? "R3" : (s ? "R2" : "R1");
        chk(vld === m_vld, {lt, "/R4 valid"}, int'(vld), int'(m_vld));
        if (m_vld) chk(word === m_word, {lt, "/R4 word"}, int'(word), int'(m_word));
        chk(sync === m_sync, "R6/R7 byte_sync", int'(sync), int'(m_sync));
        if (sync === 1'b1) begin sync_seen++; last_sync_word = word; end
        rst = r; a_in = a; b_in = b; sel = s; loop = l; algn = e; tx_in = t;
        #1;
        chk(tx_out === (l ? 1'b1 : t), "R3 tx_ser_out", int'(tx_out), int'(l ? 1'b1 : t));
        if (r) begin
            m_sr = '0; m_cnt = 0; m_pend = 0; m_vld = 0; m_sync = 0; m_word = '0;
        end else begin
            bsel = l ? t : (s ? b : a);
            nxt  = {bsel, m_sr[9:1]};
            if (is_comma(nxt) && e) begin
                m_cnt = 7; m_vld = 0; m_sync = 0; m_pend = 1;
            end else if (m_cnt == 9) begin
                m_vld = 1; m_word = nxt; m_sync = m_pend && e; m_pend = 0; m_cnt = 0;
            end else begin
                m_vld = 0; m_sync = 0; m_cnt++; m_pend = m_pend && e;
            end
            m_sr = nxt;
        end
    endtask

    // comma group 0,0,1,1,1,1,1,0,1,0 in arrival order -> 10'h17C
    localparam logic [9:0] COMMA_WORD = 10'h17C;

    task automatic send_on(input logic [9:0] v, input int n, input bit on_b,
                           input bit s, input bit l, input bit e);
        for (int i = 0; i < n; i++) begin
            if (l)         step(0, 0, 0, s, 1, e, v[i]);
            else if (on_b) step(0, i[0], v[i], s, 0, e, 1'b0);
            else           step(0, v[i], i[0], s, 0, e, 1'b0);
        end
    endtask

    task automatic filler(input int n, input bit s, input bit l, input bit e);
        for (int i = 0; i < n; i++) step(0, i[0], i[0], s, l, e, i[0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd7719));
        repeat (3) step(1, 0, 0, 0, 0, 0, 0);
        chk(vld === 1'b0 && sync === 1'b0 && word === '0, "R8 reset state",
            int'({vld, sync, word}), 0);

        // R5/R6: comma at every bit offset on lane A
        for (int k = 0; k < 10; k++) begin
            step(1, 0, 0, 0, 0, 1, 0);
            base = sync_seen;
            filler(k, 0, 0, 1);
            send_on(COMMA_WORD, 10, 0, 0, 0, 1);
            filler(14, 0, 0, 1);
            chk(sync_seen == base + 1, "R6 one sync per comma", sync_seen - base, 1);
            chk(last_sync_word == COMMA_WORD, "R5 aligned word", int'(last_sync_word), int'(COMMA_WORD));
        end

        // R7: comma with alignment disabled
        step(1, 0, 0, 0, 0, 0, 0);
        base = sync_seen;
        filler(3, 0, 0, 0);
        send_on(COMMA_WORD, 10, 0, 0, 0, 0);
        filler(20, 0, 0, 0);
        chk(sync_seen == base, "R7 no sync while disabled", sync_seen - base, 0);

        // R6: enable dropped before the aligned word completes
        base = sync_seen;
        send_on(COMMA_WORD, 8, 0, 0, 0, 1);
        filler(15, 0, 0, 0);
        chk(sync_seen == base, "R6 abandon on enable drop", sync_seen - base, 0);

        // R2/R1: comma on lane B, selected then unselected
        base = sync_seen;
        send_on(COMMA_WORD, 10, 1, 1, 0, 1);
        filler(12, 1, 0, 1);
        chk(sync_seen == base + 1, "R2 lane B comma", sync_seen - base, 1);
        base = sync_seen;
        send_on(COMMA_WORD, 10, 1, 0, 0, 1);
        filler(12, 0, 0, 1);
        chk(sync_seen == base, "R1 lane B ignored", sync_seen - base, 0);

        // R3: enter loopback, comma on transmit stream, then leave
        base = sync_seen;
        send_on(COMMA_WORD, 10, 0, 1, 1, 1);
        filler(12, 1, 1, 1);
        chk(sync_seen == base + 1, "R3 loopback comma", sync_seen - base, 1);
        filler(12, 0, 0, 1);

        // constrained random mix
        begin
            bit s = 0, l = 0, e = 1;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(0, 49) == 0) s = ~s;
                if ($urandom_range(0, 99) == 0) l = ~l;
                if ($urandom_range(0, 39) == 0) e = ~e;
                if ($urandom_range(0, 199) == 0)
                    send_on(COMMA_WORD, 10, s, s, l, e);
                else
                    step(0, 1'($urandom), 1'($urandom), s, l, e, 1'($urandom));
            end
        end
        step(0, 0, 0, 0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule